// File: doc/BRIEF.md
# DAC Sample Holding and Transfer Controller

This block is the digital front end of a 10-bit digital-to-analog converter that uses a double register. Software or a DMA channel writes each new sample into a holding register over a simple register bus. The block then moves the sample into the output register, whose contents drive the converter's code input. The move happens either on the same write or later, on a rising edge of one selected timer waveform input. The output register is only read back over the bus and is never written directly.

A mode register holds the controls: trigger enable, trigger input select, 8-bit or 10-bit resolution, and interrupt enable. In 8-bit mode the written byte is placed in the upper eight bits of the code. The DMA transfer-size output tells the DMA engine to move bytes in that mode and half-words in 10-bit mode. A data-ready flag shows that a sample is waiting for its trigger. With the interrupt enabled, this flag raises the interrupt line so software can supply the next sample.

The transfer logic is a two-state machine. EMPTY means no sample is waiting. PENDING means a sample is held and waits for a trigger edge. The transitions are:
- HOLD_WR_TRIG: a hold write while triggering is enabled moves EMPTY to PENDING.
- TRIG_EDGE: a selected rising edge with no write in the same cycle moves PENDING to EMPTY.
- IMM_WR: a hold write while triggering is disabled moves either state to EMPTY.
- REFILL: a hold write in PENDING, with or without a coincident edge, stays in PENDING.

Top module: `dac_hold_ctrl`

## Requirements
- R1: Reset state. After reset, `dac_code` is 0, `irq` is 0 and `dma_half` is 1. The mode, holding, output and status registers all read 0.
- R2: The output register (bus address 2) is read-only. Writing it leaves `dac_code` and the read-back value unchanged.
- R3: Immediate mode. With trigger enable (mode bit 0) at 0, a write to the holding register (address 1) appears on `dac_code` on the next clock edge, and data-ready (status bit 0, address 3) stays 0.
- R4: Triggered mode. With trigger enable at 1, a hold write sets data-ready and leaves `dac_code` unchanged. A rising edge on the selected `trig_in` bit copies the held value to `dac_code` on the third clock edge after the input rises, and clears data-ready.
- R5: Only a rising edge on the input chosen by the select field (mode bits 5:4) triggers a transfer. Edges on other inputs, falling edges, and any select value of `NUM_TRIG` or above cause no transfer.
- R6: Resolution (mode bit 1). When set (8-bit mode), the code is the written bits 7:0 followed by two zero bits, and written bits 9:8 are ignored. When clear, the code is written bits 9:0.
- R7: A second hold write before any trigger replaces the held value and keeps data-ready set. The next trigger transfers the newest value.
- R8: When a hold write and a selected trigger edge land on the same clock edge, the output takes the previously held value, the holding register takes the new value, and data-ready stays set.
- R9: `irq` is high exactly while data-ready is set and interrupt enable (mode bit 2) is 1.
- R10: `dma_half` is 1 in 10-bit mode and 0 in 8-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | 2 | Register index: 0 mode, 1 hold, 2 output, 3 status |
| bus_wdata | input | 10 | Write data |
| bus_rdata | output | 10 | Read data for `bus_addr` (combinational) |
| trig_in | input | NUM_TRIG | Asynchronous timer waveform trigger inputs |
| dac_code | output | 10 | Code driven to the converter |
| dma_half | output | 1 | DMA transfer size: 1 half-word, 0 byte |
| irq | output | 1 | Interrupt request |

## Verification
The transfer path is exercised with four patterns, each of which separates a different fault:
- Immediate writes in both resolutions expose wrong shifting or a late transfer.
- Triggered writes, pulsed first on a non-selected input, then on the selected input, then with a falling edge, show whether the select and edge polarity are honoured and whether the three-cycle synchronizer latency is right.
- Back-to-back writes before a trigger show which value the trigger transfers.
- A write placed on exactly the cycle the synchronized edge arrives separates the old-value rule of R8 from a design that passes the new value through or drops data-ready.

A select value above the last input and a write to the read-only output register confirm that neither disturbs the code.

// File: rtl/dac_hold_pkg.sv
package dac_hold_pkg;

    localparam int CODE_W = 10;
    localparam int BUS_W  = 10;

    typedef enum logic [1:0] {
        ADR_MODE = 2'd0,
        ADR_HOLD = 2'd1,
        ADR_OUT  = 2'd2,
        ADR_STAT = 2'd3
    } reg_addr_e;

    localparam int BIT_TEN = 0;
    localparam int BIT_RES = 1;
    localparam int BIT_IEN = 2;
    localparam int BIT_SEL = 4;

    typedef enum logic {
        ST_EMPTY   = 1'b0,
        ST_PENDING = 1'b1
    } xfer_state_e;

endpackage

// File: rtl/dac_trig_sync.sv
module dac_trig_sync #(
    parameter int NUM_TRIG = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TRIG-1:0] trig_async,
    output logic [NUM_TRIG-1:0] trig_rise
);

    for (genvar g = 0; g < NUM_TRIG; g++) begin : g_chan
        logic meta_q, sync_q, prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= trig_async[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign trig_rise[g] = sync_q & ~prev_q;
    end

endmodule

// File: rtl/dac_regs.sv
module dac_regs
    import dac_hold_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [CODE_W-1:0] hold_code,
    input  logic [CODE_W-1:0] out_code,
    input  logic              ready,
    output logic              trig_en,
    output logic              res8,
    output logic              irq_en,
    output logic [SEL_W-1:0]  trig_sel,
    output logic              hold_wr,
    output logic [CODE_W-1:0] hold_wcode
);

    reg_addr_e addr;
    assign addr = reg_addr_e'(bus_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_en  <= 1'b0;
            res8     <= 1'b0;
            irq_en   <= 1'b0;
            trig_sel <= '0;
        end else if (bus_wr && addr == ADR_MODE) begin
            trig_en  <= bus_wdata[BIT_TEN];
            res8     <= bus_wdata[BIT_RES];
            irq_en   <= bus_wdata[BIT_IEN];
            trig_sel <= bus_wdata[BIT_SEL +: SEL_W];
        end
    end

    assign hold_wr    = bus_wr && (addr == ADR_HOLD);
    assign hold_wcode = res8 ? {bus_wdata[7:0], 2'b00} : bus_wdata[CODE_W-1:0];

    always_comb begin
        bus_rdata = '0;
        unique case (addr)
            ADR_MODE: begin
                bus_rdata[BIT_TEN]            = trig_en;
                bus_rdata[BIT_RES]            = res8;
                bus_rdata[BIT_IEN]            = irq_en;
                bus_rdata[BIT_SEL +: SEL_W]   = trig_sel;
            end
            ADR_HOLD: bus_rdata[CODE_W-1:0] = hold_code;
            ADR_OUT:  bus_rdata[CODE_W-1:0] = out_code;
            ADR_STAT: bus_rdata[0]          = ready;
        endcase
    end

endmodule

// File: rtl/dac_xfer_fsm.sv
module dac_xfer_fsm
    import dac_hold_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CODE_W-1:0] wcode,
    input  logic              trig_en,
    input  logic              trig_hit,
    output logic [CODE_W-1:0] hold_code,
    output logic [CODE_W-1:0] out_code,
    output logic              ready
);

    xfer_state_e       state_q, state_d;
    logic [CODE_W-1:0] hold_d, out_d;
    logic              edge_ok;

    assign edge_ok = trig_en & trig_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_EMPTY;
            hold_code <= '0;
            out_code  <= '0;
        end else begin
            state_q   <= state_d;
            hold_code <= hold_d;
            out_code  <= out_d;
        end
    end

    always_comb begin
        state_d = state_q;
        hold_d  = hold_code;
        out_d   = out_code;
        if (wr && !trig_en) begin
            // IMM_WR
            hold_d  = wcode;
            out_d   = wcode;
            state_d = ST_EMPTY;
        end else begin
            unique case (state_q)
                ST_EMPTY: begin
                    if (edge_ok) out_d = hold_code;
                    if (wr) begin
                        // HOLD_WR_TRIG
                        hold_d  = wcode;
                        state_d = ST_PENDING;
                    end
                end
                ST_PENDING: begin
                    if (edge_ok) out_d = hold_code;
                    if (wr) begin
                        // REFILL
                        hold_d  = wcode;
                        state_d = ST_PENDING;
                    end else if (edge_ok) begin
                        // TRIG_EDGE
                        state_d = ST_EMPTY;
                    end
                end
            endcase
        end
    end

    assign ready = (state_q == ST_PENDING);

endmodule

// File: rtl/dac_hold_ctrl.sv
module dac_hold_ctrl
    import dac_hold_pkg::*;
#(
    parameter int NUM_TRIG = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [1:0]          bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic [NUM_TRIG-1:0] trig_in,
    output logic [CODE_W-1:0]   dac_code,
    output logic                dma_half,
    output logic                irq
);

    localparam int SEL_W = (NUM_TRIG < 2) ? 1 : $clog2(NUM_TRIG);
    localparam int SEL_N = 1 << SEL_W;

    logic [NUM_TRIG-1:0] rise_w;
    logic [SEL_N-1:0]    rise_ext;
    logic [SEL_W-1:0]    trig_sel_w;
    logic                trig_en_w, res8_w, irq_en_w, ready_w, hold_wr_w;
    logic [CODE_W-1:0]   hold_wcode_w, hold_code_w;

    dac_trig_sync #(.NUM_TRIG(NUM_TRIG)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_async(trig_in),
        .trig_rise (rise_w)
    );

    always_comb begin
        rise_ext = '0;
        rise_ext[NUM_TRIG-1:0] = rise_w;
    end

    dac_regs #(.SEL_W(SEL_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .hold_code (hold_code_w),
        .out_code  (dac_code),
        .ready     (ready_w),
        .trig_en   (trig_en_w),
        .res8      (res8_w),
        .irq_en    (irq_en_w),
        .trig_sel  (trig_sel_w),
        .hold_wr   (hold_wr_w),
        .hold_wcode(hold_wcode_w)
    );

    dac_xfer_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (hold_wr_w),
        .wcode    (hold_wcode_w),
        .trig_en  (trig_en_w),
        .trig_hit (rise_ext[trig_sel_w]),
        .hold_code(hold_code_w),
        .out_code (dac_code),
        .ready    (ready_w)
    );

    assign dma_half = ~res8_w;
    assign irq      = ready_w & irq_en_w;

endmodule

// File: rtl/dac_hold_ctrl_chk.sv
module dac_hold_ctrl_chk
    import dac_hold_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [CODE_W-1:0] dac_code,
    input logic              dma_half,
    input logic              irq,
    input logic              ready,
    input logic              trig_en,
    input logic              res8
);

    assert_out_readonly_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2 && !trig_en) |=> $stable(dac_code));

    assert_immediate_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1 && !trig_en) |=> !ready);

    assert_pending_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1 && trig_en) |=> ready);

    assert_byte_low_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1 && !trig_en && res8) |=> (dac_code[1:0] == 2'b00));

    assert_irq_needs_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ready);

    assert_size_follows_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=> (dma_half == !$past(bus_wdata[BIT_RES])));

endmodule

bind dac_hold_ctrl dac_hold_ctrl_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .dac_code (dac_code),
    .dma_half (dma_half),
    .irq      (irq),
    .ready    (ready_w),
    .trig_en  (trig_en_w),
    .res8     (res8_w)
);

// File: tb/dac_hold_ctrl_tb_top.sv
`timescale 1ns/1ps
module dac_hold_ctrl_tb_top;

    localparam int NT = 3;

    typedef struct {
        logic [9:0] code;
        string      tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic [9:0]    bus_wdata = '0;
    logic [9:0]    bus_rdata;
    logic [NT-1:0] trig_in = '0;
    logic [9:0]    dac_code;
    logic          dma_half, irq;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 0;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    dac_hold_ctrl #(.NUM_TRIG(NT)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_in(trig_in),
        .dac_code(dac_code), .dma_half(dma_half), .irq(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic push(logic [9:0] code, string tag);
        exp_t e;
        e.code = code;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    // called at a negedge; write captured on next posedge
    task automatic bus_write(logic [1:0] a, logic [9:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [1:0] a, output logic [9:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_trig(int idx, logic v);
        trig_in[idx] = v;
        repeat (3) @(negedge clk);
    endtask

    // scoreboard monitor
    initial begin
        logic [9:0] prev;
        prev = '0;
        forever begin
            @(negedge clk);
            if (rst_n && !done && dac_code !== prev) begin
                if (exp_q.size() == 0) begin
                    check("R2/R5 unexpected code change", {22'd0, dac_code}, {22'd0, prev});
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(e.tag, {22'd0, dac_code}, {22'd0, e.code});
                end
                prev = dac_code;
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [9:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 code", {22'd0, dac_code}, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'h0);
        check("R1 dma_half", {31'd0, dma_half}, 32'h1);
        for (int a = 0; a < 4; a++) begin
            bus_read(a[1:0], rd);
            check("R1 register read", {22'd0, rd}, 32'h0);
        end
        @(negedge clk);

        // R3 immediate 10-bit
        push(10'h155, "R3 immediate");
        bus_write(2'd1, 10'h155);
        bus_read(2'd3, rd);
        check("R3 ready stays 0", {22'd0, rd}, 32'h0);
        @(negedge clk);
        push(10'h2AB, "R6 10-bit code");
        bus_write(2'd1, 10'h2AB);

        // R6/R10 8-bit mode
        bus_write(2'd0, 10'h002);
        check("R10 byte size", {31'd0, dma_half}, 32'h0);
        push(10'h314, "R6 8-bit shift");
        bus_write(2'd1, 10'h3C5);

        // R2 read-only output
        bus_write(2'd2, 10'h2AA);
        bus_read(2'd2, rd);
        check("R2 out readback", {22'd0, rd}, 32'h314);
        @(negedge clk);

        // R4/R9 triggered, select 1, irq enabled, 10-bit
        bus_write(2'd0, 10'h015);
        check("R10 half size", {31'd0, dma_half}, 32'h1);
        bus_write(2'd1, 10'h0F0);
        bus_read(2'd3, rd);
        check("R4 ready set", {22'd0, rd}, 32'h1);
        check("R9 irq high", {31'd0, irq}, 32'h1);
        check("R4 code held", {22'd0, dac_code}, 32'h314);
        @(negedge clk);
        set_trig(0, 1'b1);
        set_trig(0, 1'b0);
        check("R5 other input ignored", {22'd0, dac_code}, 32'h314);
        push(10'h0F0, "R4 trigger transfer");
        trig_in[1] = 1'b1;
        repeat (2) @(negedge clk);
        check("R4 not before third edge", {22'd0, dac_code}, 32'h314);
        @(negedge clk);
        check("R4 transfer on third edge", {22'd0, dac_code}, 32'h0F0);
        bus_read(2'd3, rd);
        check("R4 ready cleared", {22'd0, rd}, 32'h0);
        check("R9 irq low", {31'd0, irq}, 32'h0);
        @(negedge clk);
        bus_write(2'd1, 10'h0F1);
        set_trig(1, 1'b0);
        check("R5 falling edge ignored", {22'd0, dac_code}, 32'h0F0);

        // R7 overwrite
        bus_write(2'd1, 10'h111);
        bus_write(2'd1, 10'h222);
        bus_read(2'd3, rd);
        check("R7 ready kept", {22'd0, rd}, 32'h1);
        @(negedge clk);
        push(10'h222, "R7 newest transferred");
        set_trig(1, 1'b1);
        set_trig(1, 1'b0);

        // R8 collision
        bus_write(2'd1, 10'h0AA);
        push(10'h0AA, "R8 old value out");
        trig_in[1] = 1'b1;
        repeat (2) @(negedge clk);
        bus_write(2'd1, 10'h0BB);
        check("R8 code old", {22'd0, dac_code}, 32'h0AA);
        bus_read(2'd1, rd);
        check("R8 hold new", {22'd0, rd}, 32'h0BB);
        bus_read(2'd3, rd);
        check("R8 ready kept", {22'd0, rd}, 32'h1);
        @(negedge clk);
        set_trig(1, 1'b0);
        push(10'h0BB, "R8 new value next trigger");
        set_trig(1, 1'b1);
        set_trig(1, 1'b0);

        // R9 irq disabled
        bus_write(2'd0, 10'h011);
        bus_write(2'd1, 10'h123);
        check("R9 irq masked", {31'd0, irq}, 32'h0);

        // R5 select out of range
        bus_write(2'd0, 10'h031);
        for (int i = 0; i < NT; i++) set_trig(i, 1'b1);
        for (int i = 0; i < NT; i++) set_trig(i, 1'b0);
        check("R5 invalid select no transfer", {22'd0, dac_code}, 32'h0BB);
        bus_read(2'd3, rd);
        check("R5 ready still set", {22'd0, rd}, 32'h1);
        @(negedge clk);

        // R3 immediate from pending
        bus_write(2'd0, 10'h000);
        push(10'h3FF, "R3 immediate after pending");
        bus_write(2'd1, 10'h3FF);
        bus_read(2'd3, rd);
        check("R3 ready cleared", {22'd0, rd}, 32'h0);
        repeat (2) @(negedge clk);
        check("scoreboard drained", exp_q.size(), 32'd0);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule